// File: doc/BRIEF.md
# Two-Wire EEPROM Pin Port

This block lets processor software operate a two-wire serial EEPROM by toggling pins directly. A single write register carries three bits: a clock level, a data level and a read-direction flag. Software performs every protocol step itself, including start and stop conditions, address and data bytes, and acknowledge handling. The block only holds the pin levels that software last wrote and reports the state of the data line.

Both pins are open-drain. A 0 pulls the line low, and a 1 releases it to an external pull-up. While the direction flag is set, the data pin stays released so that the EEPROM can drive it. Software then reads the line through a read window in the work-memory region below program space. In that window one data bit carries the sampled line. The block raises a lane-enable output so that the bus multiplexer drives that one bit and leaves the other seven bits as open bus.

Top module: `eeprom_pin_port`

## Requirements
- R1: On reset, the clock and data pins are both released (drive-low outputs are 0) and the direction flag is 0.
- R2: A write whose address matches offset 0xD under mask 0x800F loads the control register. Writes to any other address leave the pins unchanged.
- R3: Control bit 5 sets the clock pin. A 1 releases it (scl_drive_low=0) and a 0 pulls it low (scl_drive_low=1), starting the cycle after the write.
- R4: Control bit 6 sets the data pin the same way, but only while the direction flag (control bit 7) is 0.
- R5: While the direction flag is 1, the data pin is released whatever the value of bit 6.
- R6: A read whose address matches 0x6000 under mask 0xE000 asserts rd_lane_en (one-hot, bit 4 only). Any other read, or no read, leaves rd_lane_en at 0.
- R7: During such a read, rd_data bit 4 equals the sampled data line (sda_in), and all other rd_data bits are 0.
- R8: The control register keeps its value across reads and across writes to non-matching addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe |
| sda_in | input | 1 | Level sensed on the data line |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| rd_data | output | 8 | Read data, valid on enabled lanes |
| rd_lane_en | output | 8 | Per-bit drive enable for the bus multiplexer |

## Verification
The bench writes to address aliases that share the low nibble 0xD, and to near misses such as 0x800C and 0x000D. A decoder that checks too few address bits would move the pins on a near miss, and one that checks too many would ignore an alias. It sets the direction flag together with bit 6 at 0. A design that lets bit 6 win would pull the data line low while the EEPROM is trying to drive it. Reads inside and outside the window check the lane enables: a wrong window or wrong lane would push a driven value onto open-bus bits or onto the wrong bit.

// File: rtl/eeprom_port_pkg.sv
package eeprom_port_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int SCL_BIT  = 5;
  localparam int SDA_BIT  = 6;
  localparam int DIR_BIT  = 7;
  localparam int RD_LANE  = 4;

  typedef struct packed {
    logic dir_rd;
    logic sda_lvl;
    logic scl_lvl;
  } pin_ctrl_t;
endpackage

// File: rtl/addr_match.sv
module addr_match #(
  parameter int AW = 16,
  parameter logic [AW-1:0] MASK  = '0,
  parameter logic [AW-1:0] MATCH = '0
) (
  input  logic [AW-1:0] addr,
  input  logic          strobe,
  output logic          hit
);
  always_comb hit = strobe && ((addr & MASK) == (MATCH & MASK));
endmodule

// File: rtl/pin_ctrl_reg.sv
module pin_ctrl_reg
  import eeprom_port_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  output pin_ctrl_t     ctrl
);
  pin_ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (load) begin
      ctrl_d.scl_lvl = wdata[SCL_BIT];
      ctrl_d.sda_lvl = wdata[SDA_BIT];
      ctrl_d.dir_rd  = wdata[DIR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.scl_lvl <= 1'b1;
      ctrl_q.sda_lvl <= 1'b1;
      ctrl_q.dir_rd  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl = ctrl_q;

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ctrl_q));
  // R2
  load_takes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ctrl_q.scl_lvl == $past(wdata[SCL_BIT])) && (ctrl_q.dir_rd == $past(wdata[DIR_BIT])));
endmodule

// File: rtl/eeprom_pin_port.sv
module eeprom_pin_port
  import eeprom_port_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter logic [AW-1:0] CTRL_MASK  = 16'h800F,
  parameter logic [AW-1:0] CTRL_ADDR  = 16'h800D,
  parameter logic [AW-1:0] WIN_MASK   = 16'hE000,
  parameter logic [AW-1:0] WIN_ADDR   = 16'h6000,
  parameter int LANE = RD_LANE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          sda_in,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] rd_lane_en
);
  logic      ctrl_hit;
  logic      win_hit;
  pin_ctrl_t ctrl;

  addr_match #(.AW(AW), .MASK(CTRL_MASK), .MATCH(CTRL_ADDR)) u_wr_dec (
    .addr(bus_addr), .strobe(bus_wr), .hit(ctrl_hit));

  addr_match #(.AW(AW), .MASK(WIN_MASK), .MATCH(WIN_ADDR)) u_rd_dec (
    .addr(bus_addr), .strobe(bus_rd), .hit(win_hit));

  pin_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(ctrl_hit), .wdata(bus_wdata), .ctrl(ctrl));

  always_comb begin
    scl_drive_low = ~ctrl.scl_lvl;
    sda_drive_low = ~ctrl.sda_lvl & ~ctrl.dir_rd;
  end

  always_comb begin
    rd_data    = '0;
    rd_lane_en = '0;
    if (win_hit) begin
      rd_data[LANE]    = sda_in;
      rd_lane_en[LANE] = 1'b1;
    end
  end

  // R5
  dir_releases_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && bus_wdata[DIR_BIT]) |=> !sda_drive_low);
  // R3
  scl_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> (scl_drive_low == !$past(bus_wdata[SCL_BIT])));
  // R6
  lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_lane_en) && (!bus_rd -> rd_lane_en == '0));
  // R7
  lane_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~rd_lane_en) == '0);
  // R1
  reset_released_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!scl_drive_low && !sda_drive_low));
endmodule

// File: tb/eeprom_pin_port_tb.sv
module eeprom_pin_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        sda_in = 1'b1;
  logic        scl_drive_low, sda_drive_low;
  logic [7:0]  rd_data, rd_lane_en;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_pin_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .sda_in(sda_in),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .rd_data(rd_data), .rd_lane_en(rd_lane_en));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0;
  endtask

  task automatic pins(input string req, input logic scl_low, input logic sda_low);
    check(req, {14'd0, scl_drive_low, sda_drive_low}, {14'd0, scl_low, sda_low});
  endtask

  task automatic t_reset;
    pins("R1 reset pins", 1'b0, 1'b0);
    wr(16'h800D, 8'h60); // dir 0, both released
    pins("R1 dir cleared", 1'b0, 1'b0);
  endtask

  task automatic t_levels;
    wr(16'h800D, 8'h00);
    pins("R3 R4 both low", 1'b1, 1'b1);
    wr(16'h800D, 8'h20);
    pins("R3 scl released", 1'b0, 1'b1);
    wr(16'h800D, 8'h40);
    pins("R4 sda released", 1'b1, 1'b0);
    wr(16'hFFFD, 8'h1F); // alias, bits 5/6 zero
    pins("R2 alias write", 1'b1, 1'b1);
  endtask

  task automatic t_decode;
    wr(16'h800D, 8'h60);
    wr(16'h800C, 8'h00);
    pins("R2 near miss 800C", 1'b0, 1'b0);
    wr(16'h000D, 8'h00);
    pins("R2 near miss 000D", 1'b0, 1'b0);
    wr(16'h6000, 8'h00);
    pins("R8 window write ignored", 1'b0, 1'b0);
  endtask

  task automatic t_direction;
    wr(16'h800D, 8'h80); // dir 1, sda bit 0, scl 0
    pins("R5 dir forces release", 1'b1, 1'b0);
    wr(16'h800D, 8'h00);
    pins("R4 dir off pulls", 1'b1, 1'b1);
  endtask

  task automatic t_read;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 16'h6000; sda_in = 1'b1;
    #1;
    check("R6 lane in window", {8'd0, rd_lane_en}, 16'h0010);
    check("R7 data high", {8'd0, rd_data}, 16'h0010);
    sda_in = 1'b0; bus_addr = 16'h7FFF;
    #1;
    check("R7 data low", {8'd0, rd_data}, 16'h0000);
    check("R6 lane top of window", {8'd0, rd_lane_en}, 16'h0010);
    bus_addr = 16'h8000;
    #1;
    check("R6 outside window", {8'd0, rd_lane_en}, 16'h0000);
    bus_addr = 16'h5FFF;
    #1;
    check("R6 below window", {8'd0, rd_lane_en}, 16'h0000);
    bus_rd = 1'b0; bus_addr = 16'h6000;
    #1;
    check("R6 no strobe", {8'd0, rd_lane_en}, 16'h0000);
    bus_addr = '0; sda_in = 1'b1;
    @(negedge clk);
    pins("R8 hold across reads", 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_decode();
    t_direction();
    t_read();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule